// File: doc/BRIEF.md
# RTC Deep-Sleep Retention and Wakeup Controller

This block is the always-on part of a real-time clock domain that outlives a deep low-power state in which the main core supply is switched off. It keeps four interrupt enables, four event flags, a hold bit and a lock bit. Four event sources feed it: a time event, an alarm, a prescaler tick and an oscillator fault. When software asks for power-down with the clock running, the block drops the stale flags of disabled sources, sets the lock and goes to sleep. While asleep it records every event. Only an enabled event wakes the core.

On wakeup the block holds the core in reset for a fixed number of always-on clock cycles. It then leaves the core running with the retained configuration frozen. Software restores its own state and then clears the lock. That releases the enables and flags, and any enabled flag that is still pending drives its interrupt line.

Top module: `rtc_lp_retain`

## Requirements
- R1: After reset the lock, core reset, wake request, flags, enables and interrupt lines are all 0, and the hold bit is 1.
- R2: Event bit positions are 0 = time event, 1 = alarm, 2 = prescaler tick, 3 = oscillator fault. An event pulse sets its flag on the next clock edge. While unlocked, interrupt line i equals flag i AND enable i.
- R3: A power-down request while the hold bit is 1 is ignored: the lock stays 0 and the enables stay writable.
- R4: A power-down request with hold 0 sets the lock on the next clock edge.
- R5: On entry, each set flag whose enable is 0 is cleared, and each flag whose enable is 1 is kept.
- R6: While asleep, every event sets its flag, whether or not its enable is set.
- R7: While asleep, wake_req is high in the same cycle as an event whose enable is 1, and it is low for an event of a disabled source.
- R8: After a wakeup, core_rst is high for exactly 4 cycles. It then falls, and the lock, enables and flags keep their values.
- R9: While the lock is 1, writes to the enables (sel 0) and the flag clears (sel 1) are ignored, and all interrupt lines are 0.
- R10: Writing sel 2 with data bit 1 set while locked and awake clears the lock. Any pending enabled flag then drives its interrupt line.
- R11: Writing sel 1 clears each flag whose data bit is 1. An event in the same cycle as the clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Always-on reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 enables, 1 flag clear, 2 control (bit0 hold, bit1 unlock) |
| reg_wdata | input | 4 | Write data |
| pd_req | input | 1 | Power-down request pulse |
| ev_in | input | 4 | Event pulses (time, alarm, prescaler, oscillator fault) |
| wake_req | output | 1 | Wakeup request |
| core_rst | output | 1 | Core reset, active high |
| lock_o | output | 1 | Retention lock status |
| hold_o | output | 1 | Hold bit |
| ien_o | output | 4 | Retained enables |
| flag_o | output | 4 | Retained flags |
| irq_o | output | 4 | Interrupt lines |

## Verification
A wrong sleep or lock state appears at lock_o and irq_o on the cycle after the request or the write that should have moved it. A flag wrongly cleared or kept at entry shows on flag_o one edge after pd_req. A wake taken for a disabled source, or a missed wake, shows on wake_req in the event cycle itself. A miscounted reset window shows as a core_rst pulse that is one or more cycles too short or too long.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE       = 2'd0,
    ST_SLEEP        = 2'd1,
    ST_WAKE_RESET   = 2'd2,
    ST_LOCKED_AWAKE = 2'd3
  } lp_state_t;

  localparam logic [1:0] SEL_IEN  = 2'd0;
  localparam logic [1:0] SEL_FCLR = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  // flags that survive entry: only those with their enable set
  function automatic logic [3:0] entry_keep(input logic [3:0] flags, input logic [3:0] ien);
    return flags & ien;
  endfunction

  function automatic logic wake_hit(input logic [3:0] ev, input logic [3:0] ien);
    return |(ev & ien);
  endfunction
endpackage

// File: rtl/rtc_lp_ctrl.sv
module rtc_lp_ctrl
  import rtc_lp_pkg::*;
#(
  parameter int RST_CYCLES = 4,
  localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_req,
  input  logic      ctrl_wr,
  input  logic      ctrl_hold,
  input  logic      ctrl_unlock,
  input  logic      hit,
  output lp_state_t state,
  output logic      lock,
  output logic      hold,
  output logic      enter_evt,
  output logic      wake_evt,
  output logic      core_rst
);
  logic [CW-1:0] cnt;
  logic          unlock_evt;
  logic          rst_done;

  assign enter_evt  = (state == ST_ACTIVE) && pd_req && !hold;
  assign wake_evt   = (state == ST_SLEEP) && hit;
  assign unlock_evt = (state == ST_LOCKED_AWAKE) && ctrl_wr && ctrl_unlock;
  assign rst_done   = (cnt == CW'(RST_CYCLES - 1));
  assign core_rst   = (state == ST_WAKE_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_ACTIVE;
      lock  <= 1'b0;
      hold  <= 1'b1;
      cnt   <= '0;
    end else begin
      if (ctrl_wr && (state == ST_ACTIVE || state == ST_LOCKED_AWAKE))
        hold <= ctrl_hold;
      unique case (state)
        ST_ACTIVE: if (enter_evt) begin
          state <= ST_SLEEP;
          lock  <= 1'b1;
        end
        ST_SLEEP: if (wake_evt) begin
          state <= ST_WAKE_RESET;
          cnt   <= '0;
        end
        ST_WAKE_RESET: begin
          cnt <= cnt + 1'b1;
          if (rst_done) state <= ST_LOCKED_AWAKE;
        end
        ST_LOCKED_AWAKE: if (unlock_evt) begin
          state <= ST_ACTIVE;
          lock  <= 1'b0;
        end
        default: state <= ST_ACTIVE;
      endcase
    end
  end

  // R3
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && pd_req && hold) |=> (state == ST_ACTIVE && !lock));
  // R4
  lock_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> lock);
  // R8
  reset_then_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (lock && state == ST_LOCKED_AWAKE));
  // R8
  wake_starts_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> core_rst);
endmodule

// File: rtl/rtc_lp_flags.sv
module rtc_lp_flags
  import rtc_lp_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] ev,
  input  logic             ien_wr,
  input  logic             fclr_wr,
  input  logic [N_SRC-1:0] wdata,
  input  logic             lock,
  input  logic             enter_evt,
  input  logic             sleeping,
  output logic [N_SRC-1:0] flags,
  output logic [N_SRC-1:0] ien,
  output logic [N_SRC-1:0] irq,
  output logic             hit
);
  logic [N_SRC-1:0] kept;

  assign kept = entry_keep(flags, ien);
  assign hit  = sleeping && wake_hit(ev, ien);
  assign irq  = lock ? '0 : (flags & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien <= '0;
    else if (ien_wr && !lock) ien <= wdata;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else if (ev[i]) flags[i] <= 1'b1;
      else if (enter_evt) flags[i] <= kept[i];
      else if (fclr_wr && !lock && wdata[i]) flags[i] <= 1'b0;
    end
  end

  // R6
  sleep_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && |ev) |=> ((flags & $past(ev)) == $past(ev)));
  // R9
  locked_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (irq == '0));
  // R9
  locked_ien_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(ien));
  // R7
  wake_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (|(ev & ien)));
endmodule

// File: rtl/rtc_lp_retain.sv
module rtc_lp_retain
  import rtc_lp_pkg::*;
#(
  parameter int N_SRC      = 4,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [N_SRC-1:0] reg_wdata,
  input  logic             pd_req,
  input  logic [N_SRC-1:0] ev_in,
  output logic             wake_req,
  output logic             core_rst,
  output logic             lock_o,
  output logic             hold_o,
  output logic [N_SRC-1:0] ien_o,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] irq_o
);
  lp_state_t state;
  logic      enter_evt, wake_evt, hit;
  logic      ien_wr, fclr_wr, ctrl_wr;

  assign ien_wr   = reg_wr && (reg_sel == SEL_IEN);
  assign fclr_wr  = reg_wr && (reg_sel == SEL_FCLR);
  assign ctrl_wr  = reg_wr && (reg_sel == SEL_CTRL);
  assign wake_req = wake_evt;

  rtc_lp_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .ctrl_wr(ctrl_wr),
    .ctrl_hold(reg_wdata[0]), .ctrl_unlock(reg_wdata[1]), .hit(hit),
    .state(state), .lock(lock_o), .hold(hold_o), .enter_evt(enter_evt),
    .wake_evt(wake_evt), .core_rst(core_rst)
  );

  rtc_lp_flags #(.N_SRC(N_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .ev(ev_in), .ien_wr(ien_wr), .fclr_wr(fclr_wr),
    .wdata(reg_wdata), .lock(lock_o), .enter_evt(enter_evt),
    .sleeping(state == ST_SLEEP), .flags(flag_o), .ien(ien_o), .irq(irq_o),
    .hit(hit)
  );
endmodule

// File: tb/test_rtc_lp_retain.sv
module test_rtc_lp_retain;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       reg_wr = 0, pd_req = 0;
  logic [1:0] reg_sel = 0;
  logic [3:0] reg_wdata = 0, ev_in = 0;
  logic       wake_req, core_rst, lock_o, hold_o;
  logic [3:0] ien_o, flag_o, irq_o;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_lp_retain i_rtc_lp_retain (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .pd_req(pd_req), .ev_in(ev_in),
    .wake_req(wake_req), .core_rst(core_rst), .lock_o(lock_o), .hold_o(hold_o),
    .ien_o(ien_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [3:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic pulse_ev(input logic [3:0] e);
    @(negedge clk); ev_in = e;
    @(negedge clk); ev_in = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; reg_wr = 0; pd_req = 0; ev_in = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 lock", lock_o, 0);
    chk("R1 core_rst", core_rst, 0);
    chk("R1 wake_req", wake_req, 0);
    chk("R1 flags", flag_o, 0);
    chk("R1 ien", ien_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 hold", hold_o, 1);
  endtask

  task automatic t_hold_block();
    do_reset();
    @(negedge clk); pd_req = 1;
    @(negedge clk); pd_req = 0;
    chk("R3 lock stays 0", lock_o, 0);
    wr(2'd0, 4'b0101);
    chk("R3 ien writable", ien_o, 4'b0101);
  endtask

  task automatic t_sleep_cycle();
    do_reset();
    wr(2'd0, 4'b1010);
    pulse_ev(4'b0011);
    chk("R2 flags", flag_o, 4'b0011);
    chk("R2 irq", irq_o, 4'b0010);
    // clear both while alarm fires again: set wins
    @(negedge clk); reg_wr = 1; reg_sel = 2'd1; reg_wdata = 4'b0011; ev_in = 4'b0010;
    @(negedge clk); reg_wr = 0; ev_in = 0;
    chk("R11 clear vs set", flag_o, 4'b0010);
    pulse_ev(4'b0001);
    wr(2'd2, 4'b0000);
    chk("R3 hold cleared", hold_o, 0);
    @(negedge clk); pd_req = 1;
    @(negedge clk); pd_req = 0;
    chk("R4 lock set", lock_o, 1);
    chk("R5 entry clear", flag_o, 4'b0010);
    chk("R9 irq masked", irq_o, 0);
    @(negedge clk); ev_in = 4'b0100;
    #1 chk("R7 no wake disabled", wake_req, 0);
    @(negedge clk); ev_in = 0;
    chk("R6 disabled event latched", flag_o, 4'b0110);
    chk("R7 no reset", core_rst, 0);
    wr(2'd0, 4'b0000);
    chk("R9 ien write in sleep", ien_o, 4'b1010);
    @(negedge clk); ev_in = 4'b1000;
    #1 chk("R7 wake enabled", wake_req, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ev_in = 0;
      chk("R8 core_rst high", core_rst, 1);
    end
    @(negedge clk);
    chk("R8 core_rst released", core_rst, 0);
    chk("R8 lock kept", lock_o, 1);
    chk("R8 ien kept", ien_o, 4'b1010);
    chk("R8 flags kept", flag_o, 4'b1110);
    wr(2'd0, 4'b1111);
    chk("R9 ien ignored", ien_o, 4'b1010);
    wr(2'd1, 4'b1111);
    chk("R9 clear ignored", flag_o, 4'b1110);
    chk("R9 irq zero", irq_o, 0);
    wr(2'd2, 4'b0010);
    chk("R10 unlock", lock_o, 0);
    chk("R10 irq released", irq_o, 4'b1010);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_hold_block();
        t_sleep_cycle();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule